// File: doc/BRIEF.md
# Qualified Bus Clock-Domain Crossing

This block carries a data word from one clock domain into a second, unrelated clock domain without synchronizing the word itself. The source side registers the word and raises a single qualifier bit. Only that qualifier passes through a flop synchronizer in the destination domain. One more destination flop delays the synchronized qualifier so that its rising edge can be detected. On that edge the destination register samples the whole bus in one go. This is safe because the source keeps the bus frozen for the whole time the destination could be loading it.

The source domain offers a request input and a busy output. A request taken while the block is idle latches the word. The qualifier then stays high for `HIGH_CYC` source cycles and low for `LOW_CYC` source cycles. Busy covers both windows. The integrator picks these counts so that each window spans at least three destination periods. The destination domain presents the word together with a one-cycle valid strobe.

Top module: `qual_bus_cdc`

## Requirements
- R1: While either reset is low, and right after both resets are released, `dst_data_o` is 0, `dst_valid_o` is 0 and `src_busy_o` is 0.
- R2: A `src_req_i` sampled high at a source clock edge while `src_busy_o` is 0 latches `src_data_i`. After that edge `src_busy_o` is 1, and it stays 1 for exactly `HIGH_CYC + LOW_CYC` source cycles.
- R3: A `src_req_i` sampled while `src_busy_o` is 1 is ignored. No extra word reaches the destination and the pending word is unaffected.
- R4: Per accepted word, the qualifier is high for exactly `HIGH_CYC` source cycles, followed by a low window of `LOW_CYC` cycles.
- R5: The source data register does not change while `src_busy_o` is 1, whatever `src_data_i` does.
- R6: `dst_data_o` changes only in a cycle in which `dst_valid_o` is 1. The load happens once, on the detected rising edge of the synchronized qualifier.
- R7: `dst_valid_o` is a single-cycle pulse, never high in two consecutive destination cycles.
- R8: Every accepted word appears on `dst_data_o` exactly once, in order of acceptance, and unchanged.
- R9: Loading is edge-triggered and does not depend on data, so a word of all zeros still produces a `dst_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_data_i | input | DATA_W | Word to send |
| src_req_i | input | 1 | Send request, taken only when not busy |
| src_busy_o | output | 1 | Source cannot accept a request |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_data_o | output | DATA_W | Received word |
| dst_valid_o | output | 1 | One-cycle strobe marking a newly loaded word |

## Verification
The bench builds the block with `DATA_W = 8`, `SYNC_STAGES = 2` and `HIGH_CYC = LOW_CYC = 6`. The source clock period is 8 ns and the destination period is 13 ns. With these values each qualifier window lasts 48 ns, a little above three destination periods. The phase between the clocks drifts from word to word, so the load lands on different destination edges relative to the source edge. The requests are sent back to back, so the minimum spacing between words is exercised. The source bus is scrambled during busy, and extra requests are raised during busy, so any loss of bus stability or any accepted spurious request would corrupt the ordered word stream.

// File: rtl/qual_bus_cdc_pkg.sv
package qual_bus_cdc_pkg;
  localparam int unsigned DEF_DATA_W = 8;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_HIGH = 2'd1,
    SRC_LOW  = 2'd2
  } src_state_e;
endpackage

// File: rtl/qual_bus_cdc_src.sv
module qual_bus_cdc_src
  import qual_bus_cdc_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned HIGH_CYC = 6,
  parameter int unsigned LOW_CYC  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              req_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic              qual_q_o
);
  localparam int unsigned MAX_CYC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  src_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SRC_IDLE;
      cnt_q    <= '0;
      data_q_o <= '0;
      qual_q_o <= 1'b0;
    end else begin
      unique case (state_q)
        SRC_IDLE: if (req_i) begin
          data_q_o <= data_i;
          qual_q_o <= 1'b1;
          state_q  <= SRC_HIGH;
          cnt_q    <= CNT_W'(HIGH_CYC - 1);
        end
        SRC_HIGH: if (cnt_q == '0) begin
          qual_q_o <= 1'b0;
          state_q  <= SRC_LOW;
          cnt_q    <= CNT_W'(LOW_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        SRC_LOW: if (cnt_q == '0) begin
          state_q <= SRC_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SRC_IDLE);
endmodule

// File: rtl/qual_bus_cdc_sync.sv
module qual_bus_cdc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qual_bus_cdc_dst.sv
module qual_bus_cdc_dst
  import qual_bus_cdc_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              qual_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic qual_sync;
  logic qual_dly_q;
  logic load;

  qual_bus_cdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (qual_i),
    .q_o    (qual_sync)
  );

  // edge-detect delay, outside the metastability chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_dly_q <= 1'b0;
    else         qual_dly_q <= qual_sync;
  end

  assign load = qual_sync & ~qual_dly_q;

  // bus is held steady by the source while load can be true
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load;
      if (load) data_o <= bus_i;
    end
  end
endmodule

// File: rtl/qual_bus_cdc.sv
module qual_bus_cdc
  import qual_bus_cdc_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HIGH_CYC    = 6,
  parameter int unsigned LOW_CYC     = 6
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_req_i,
  output logic              src_busy_o,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_valid_o
);
  logic [DATA_W-1:0] src_data_q;
  logic              src_qual;

  qual_bus_cdc_src #(
    .DATA_W   (DATA_W),
    .HIGH_CYC (HIGH_CYC),
    .LOW_CYC  (LOW_CYC)
  ) u_src (
    .clk_i    (src_clk_i),
    .rst_ni   (src_rst_ni),
    .data_i   (src_data_i),
    .req_i    (src_req_i),
    .busy_o   (src_busy_o),
    .data_q_o (src_data_q),
    .qual_q_o (src_qual)
  );

  qual_bus_cdc_dst #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dst (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .qual_i  (src_qual),
    .bus_i   (src_data_q),
    .data_o  (dst_data_o),
    .valid_o (dst_valid_o)
  );
endmodule

// File: rtl/qual_bus_cdc_chk.sv
module qual_bus_cdc_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HIGH_CYC = 6
) (
  input logic              src_clk_i,
  input logic              src_rst_ni,
  input logic              src_req_i,
  input logic              src_busy_o,
  input logic [DATA_W-1:0] src_data_q_i,
  input logic              src_qual_i,
  input logic              dst_clk_i,
  input logic              dst_rst_ni,
  input logic [DATA_W-1:0] dst_data_o,
  input logic              dst_valid_o
);
  logic [15:0] high_run_q;

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni)     high_run_q <= '0;
    else if (src_qual_i) high_run_q <= high_run_q + 1'b1;
    else                 high_run_q <= '0;
  end

  p_accept_r2: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (!src_busy_o && src_req_i) |=> (src_busy_o && src_qual_i));

  p_ignore_r3: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (src_busy_o && src_req_i) |=> !$rose(src_qual_i));

  p_high_len_r4: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $fell(src_qual_i) |-> (high_run_q == 16'(HIGH_CYC)));

  p_bus_hold_r5: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (src_busy_o && $past(src_busy_o)) |-> $stable(src_data_q_i));

  p_load_only_r6: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !$stable(dst_data_o) |-> dst_valid_o);

  p_pulse_r7: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    dst_valid_o |=> !dst_valid_o);
endmodule

bind qual_bus_cdc qual_bus_cdc_chk #(
  .DATA_W   (DATA_W),
  .HIGH_CYC (HIGH_CYC)
) u_chk (
  .src_clk_i    (src_clk_i),
  .src_rst_ni   (src_rst_ni),
  .src_req_i    (src_req_i),
  .src_busy_o   (src_busy_o),
  .src_data_q_i (src_data_q),
  .src_qual_i   (src_qual),
  .dst_clk_i    (dst_clk_i),
  .dst_rst_ni   (dst_rst_ni),
  .dst_data_o   (dst_data_o),
  .dst_valid_o  (dst_valid_o)
);

// File: tb/qual_bus_cdc_bench.sv
module qual_bus_cdc_bench;
  localparam int unsigned DW = 8;
  localparam int unsigned HC = 6;
  localparam int unsigned LC = 6;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_req = 1'b0;
  logic          src_busy;
  logic [DW-1:0] dst_data;
  logic          dst_valid;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  int rcvd   = 0;
  logic [DW-1:0] exp_q[$];

  always #4   src_clk = ~src_clk;  // 125 MHz
  always #6.5 dst_clk = ~dst_clk;  // unrelated destination clock

  qual_bus_cdc #(
    .DATA_W(DW), .SYNC_STAGES(2), .HIGH_CYC(HC), .LOW_CYC(LC)
  ) u_qual_bus_cdc (
    .src_clk_i   (src_clk),
    .src_rst_ni  (src_rst_n),
    .src_data_i  (src_data),
    .src_req_i   (src_req),
    .src_busy_o  (src_busy),
    .dst_clk_i   (dst_clk),
    .dst_rst_ni  (dst_rst_n),
    .dst_data_o  (dst_data),
    .dst_valid_o (dst_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard in destination domain
  logic          prev_valid = 1'b0;
  logic [DW-1:0] prev_data  = '0;
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        check(!prev_valid, "R7 single-cycle valid", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", int'(dst_data), -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(dst_data == e, "R8 word order/value", int'(dst_data), int'(e));
          rcvd++;
        end
      end else if (dst_data != prev_data) begin
        check(1'b0, "R6 data changed without valid", int'(dst_data), int'(prev_data));
      end
      prev_valid = dst_valid;
      prev_data  = dst_data;
    end
  end

  task automatic send(input logic [DW-1:0] w, input bit poke, input string tag);
    int n;
    while (src_busy) @(negedge src_clk);
    src_data = w;
    src_req  = 1'b1;
    exp_q.push_back(w);
    sent++;
    @(negedge src_clk);
    src_req = 1'b0;
    check(src_busy == 1'b1, tag, int'(src_busy), 1);
    n = 0;
    while (src_busy) begin
      n++;
      src_data = w ^ DW'(n * 37 + 1);  // R5: scramble the input bus while busy
      if (poke && n == 3) src_req = 1'b1;  // R3: request while busy
      else                src_req = 1'b0;
      @(negedge src_clk);
    end
    src_req = 1'b0;
    check(n == int'(HC + LC), "R2 busy length", n, int'(HC + LC));
  endtask

  initial begin
    repeat (60000) @(posedge src_clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge dst_clk);
    check(dst_data == '0 && dst_valid == 1'b0, "R1 dst in reset", int'(dst_data), 0);
    check(src_busy == 1'b0, "R1 busy in reset", int'(src_busy), 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    repeat (2) @(negedge src_clk);
    check(src_busy == 1'b0, "R1 busy after reset", int'(src_busy), 0);
    @(negedge dst_clk);
    check(dst_data == '0 && dst_valid == 1'b0, "R1 dst after reset", int'(dst_data), 0);

    send(8'h00, 1'b0, "R9 zero word accepted");
    send(8'hFF, 1'b0, "R2 accept all ones");
    send(8'hA5, 1'b1, "R3 accept with poke");
    send(8'h5A, 1'b1, "R3 accept with poke");
    for (int i = 0; i < 20; i++) send(DW'(i * 13 + 7), (i % 3) == 0, "R2 accept stream");

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge dst_clk);
    repeat (40) @(negedge dst_clk);
    check(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
    check(rcvd == sent, "R8 exactly once", rcvd, sent);
    check(dst_valid == 1'b0, "R7 idle after stream", int'(dst_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule